// File: doc/BRIEF.md
# Bit-Composable Fused Multiply-Add Engine

This engine is built from sixteen 2-bit multiplier cells. A width setting is held in a register, and it decides how the cells are grouped. The grouping gives logical multipliers whose input and weight operands are each 2, 4 or 8 bits wide, and the two widths need not match. In the narrowest setting all sixteen cells work as separate multipliers. In the widest setting all sixteen cells form one 8-bit by 8-bit product.

Every accepted beat carries three values: a packed input word, a packed weight word and an incoming 32-bit partial sum. The engine returns one 32-bit partial sum. That result is the incoming sum plus the sum of every product formed from the beat.

Each cell sign-extends its two 2-bit slices to 3 bits and multiplies them. The cell products are then shifted by their slice weights and summed in a single adder tree.

Beats enter on a valid/ready stream and leave on a second valid/ready stream, through one register stage. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. A result is consumed when `out_valid` and `out_ready` are both high at a clock edge. While a result waits unconsumed, `in_ready` is low, and the result and `out_valid` hold steady.

The width and sign settings are plain control pins. They are captured on `cfg_load` and stay fixed between layers.

Top module: `bfe_engine`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The configuration after reset is 2-bit input, 2-bit weight, both unsigned.
- R2: With both width codes at 0 (2 bits), sixteen products are summed. Input element n is `in_data[2n+1:2n]` and weight element n is `wt_data[2n+1:2n]`.
- R3: With both width codes at 1 (4 bits), four products are summed. Element n is bits `[4n+3:4n]` of each word.
- R4: Mixed widths are supported. The number of products is 64/(IW·WW). Input element n sits at `in_data[n·IW +: IW]` and weight element n at `wt_data[n·WW +: WW]`. This covers the 8/2, 2/8, 4/2 and 2/4 pairs.
- R5: With both width codes at 2 (8 bits), the result adds exactly one product of `in_data[7:0]` and `wt_data[7:0]`.
- R6: The flag `cfg_in_sgn` (or `cfg_wt_sgn`) set to 1 makes every element of that operand two's complement. Set to 0, the elements are unsigned.
- R7: `psum_out` equals `psum_in` plus the dot product, taken modulo 2^32.
- R8: Width codes 0, 1, 2 and 3 mean 2, 4, 8 and 8 bits. Settings applied with `cfg_load` govern beats accepted after that clock edge. A beat accepted at the same edge still uses the old settings.
- R9: A beat accepted at a clock edge produces `out_valid` high right after that edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `psum_out` and `out_valid` hold and `in_ready` is 0. `out_valid` falls only after a handshake.
- R11: Bits of `in_data` and `wt_data` above the elements in use do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Captures the four settings below |
| cfg_in_w | input | 2 | Input width code (0:2, 1:4, 2/3:8 bits) |
| cfg_wt_w | input | 2 | Weight width code (0:2, 1:4, 2/3:8 bits) |
| cfg_in_sgn | input | 1 | Input elements are signed |
| cfg_wt_sgn | input | 1 | Weight elements are signed |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken |
| in_data | input | 32 | Packed input elements |
| wt_data | input | 32 | Packed weight elements |
| psum_in | input | 32 | Incoming partial sum |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken |
| psum_out | output | 32 | Outgoing partial sum |

## Verification
The assertions check the stream rules on every cycle:
- the one-cycle latency;
- holding the result while stalled;
- no drop of `out_valid` without a handshake.

They also check that each cell product stays within the range a 2-bit by 2-bit multiply can reach, and that no cell product is negative when both operands are unsigned.

Some behaviour only the bench scenarios can show:
- the correctness of the sums for each width pair and sign combination;
- that unused upper bits have no effect;
- 32-bit wrap of the partial sum;
- the treatment of code 3;
- the rule that a beat accepted in the same cycle as a settings load still uses the old settings.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

  typedef enum logic [1:0] {
    WID2  = 2'd0,
    WID4  = 2'd1,
    WID8  = 2'd2,
    WID8X = 2'd3
  } width_e;

  typedef struct packed {
    width_e in_w;
    width_e wt_w;
    logic   in_sgn;
    logic   wt_sgn;
  } cfg_t;

  // log2 of (width / 2): number of slice-halvings from 2 bits
  function automatic int lg_of(width_e w);
    case (w)
      WID2:    return 0;
      WID4:    return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/bfe_cell.sv
module bfe_cell (
  input  logic              [1:0] a,
  input  logic              [1:0] b,
  input  logic                    a_sgn,
  input  logic                    b_sgn,
  output logic signed       [5:0] prod
);
  logic signed [2:0] ax;
  logic signed [2:0] bx;

  always_comb begin
    ax   = {a_sgn & a[1], a};
    bx   = {b_sgn & b[1], b};
    prod = ax * bx;
  end
endmodule

// File: rtl/bfe_route.sv
module bfe_route
  import bfe_pkg::*;
#(
  parameter int NCELL = 16,
  parameter int OPW   = 32
) (
  input  cfg_t             cfg,
  input  logic [OPW-1:0]   in_data,
  input  logic [OPW-1:0]   wt_data,
  output logic [1:0]       a_op  [NCELL],
  output logic [1:0]       b_op  [NCELL],
  output logic             a_sg  [NCELL],
  output logic             b_sg  [NCELL],
  output logic [3:0]       sh    [NCELL]
);
  localparam int IDXW = $clog2(OPW);

  for (genvar c = 0; c < NCELL; c++) begin : g_map
    always_comb begin
      int lgi, lgw, grp, rem, si, sj, ib, wb;
      lgi = lg_of(cfg.in_w);
      lgw = lg_of(cfg.wt_w);
      grp = c >> (lgi + lgw);                       // product index
      rem = c & ((1 << (lgi + lgw)) - 1);           // cell within product
      si  = rem & ((1 << lgi) - 1);                 // input slice
      sj  = rem >> lgi;                             // weight slice
      ib  = grp * (2 << lgi) + 2 * si;
      wb  = grp * (2 << lgw) + 2 * sj;
      a_op[c] = in_data[IDXW'(ib) +: 2];
      b_op[c] = wt_data[IDXW'(wb) +: 2];
      a_sg[c] = cfg.in_sgn && (si == (1 << lgi) - 1);
      b_sg[c] = cfg.wt_sgn && (sj == (1 << lgw) - 1);
      sh[c]   = 4'(2 * (si + sj));
    end
  end
endmodule

// File: rtl/bfe_reduce.sv
module bfe_reduce #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [W-1:0] terms [N],
  output logic [W-1:0] total
);
  localparam int LV = $clog2(N);

  for (genvar l = 0; l < LV; l++) begin : g_lv
    logic [W-1:0] v [N >> (l + 1)];
    for (genvar k = 0; k < (N >> (l + 1)); k++) begin : g_add
      if (l == 0) begin : g_leaf
        assign v[k] = terms[2*k] + terms[2*k+1];
      end else begin : g_node
        assign v[k] = g_lv[l-1].v[2*k] + g_lv[l-1].v[2*k+1];
      end
    end
  end

  assign total = g_lv[LV-1].v[0];
endmodule

// File: rtl/bfe_engine.sv
module bfe_engine
  import bfe_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OPW   = 32,
  parameter int NCELL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [1:0]       cfg_in_w,
  input  logic [1:0]       cfg_wt_w,
  input  logic             cfg_in_sgn,
  input  logic             cfg_wt_sgn,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_data,
  input  logic [OPW-1:0]   wt_data,
  input  logic [ACC_W-1:0] psum_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] psum_out
);
  localparam int PW = 6;

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.in_w   <= WID2;
      cfg_q.wt_w   <= WID2;
      cfg_q.in_sgn <= 1'b0;
      cfg_q.wt_sgn <= 1'b0;
    end else if (cfg_load) begin
      cfg_q.in_w   <= width_e'(cfg_in_w);
      cfg_q.wt_w   <= width_e'(cfg_wt_w);
      cfg_q.in_sgn <= cfg_in_sgn;
      cfg_q.wt_sgn <= cfg_wt_sgn;
    end
  end

  logic [1:0]              a_op [NCELL];
  logic [1:0]              b_op [NCELL];
  logic                    a_sg [NCELL];
  logic                    b_sg [NCELL];
  logic [3:0]              sh   [NCELL];
  logic signed [PW-1:0]    prod [NCELL];
  logic [ACC_W-1:0]        term [NCELL];
  logic [ACC_W-1:0]        dot;

  bfe_route #(.NCELL(NCELL), .OPW(OPW)) route_i (
    .cfg     (cfg_q),
    .in_data (in_data),
    .wt_data (wt_data),
    .a_op    (a_op),
    .b_op    (b_op),
    .a_sg    (a_sg),
    .b_sg    (b_sg),
    .sh      (sh)
  );

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    bfe_cell cell_i (
      .a     (a_op[c]),
      .b     (b_op[c]),
      .a_sgn (a_sg[c]),
      .b_sgn (b_sg[c]),
      .prod  (prod[c])
    );
    assign term[c] = {{(ACC_W-PW){prod[c][PW-1]}}, prod[c]} << sh[c];

    // R6
    prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(prod[c]) >= -6 && $signed(prod[c]) <= 9));
    // R6
    unsigned_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.in_sgn && !cfg_q.wt_sgn) |-> !prod[c][PW-1]);
  end

  bfe_reduce #(.N(NCELL), .W(ACC_W)) reduce_i (
    .terms (term),
    .total (dot)
  );

  logic             ov_q;
  logic [ACC_W-1:0] ps_q;

  assign in_ready  = !ov_q || out_ready;
  assign out_valid = ov_q;
  assign psum_out  = ps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ps_q <= '0;
    end else if (in_valid && in_ready) begin
      ov_q <= 1'b1;
      ps_q <= psum_in + dot;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(psum_out)));
  // R10
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

// File: tb/bfe_engine_tb_top.sv
module bfe_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [1:0]  cfg_in_w, cfg_wt_w;
  logic        cfg_in_sgn, cfg_wt_sgn;
  logic        in_valid, in_ready;
  logic [31:0] in_data, wt_data, psum_in;
  logic        out_valid, out_ready;
  logic [31:0] psum_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1F2E3D4C;

  logic [1:0] cur_iw = 2'd0, cur_ww = 2'd0;
  logic       cur_is = 1'b0, cur_ws = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bfe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_in_w(cfg_in_w), .cfg_wt_w(cfg_wt_w),
    .cfg_in_sgn(cfg_in_sgn), .cfg_wt_sgn(cfg_wt_sgn),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wt_data(wt_data), .psum_in(psum_in),
    .out_valid(out_valid), .out_ready(out_ready), .psum_out(psum_out)
  );

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] p,
                                        logic [1:0] iwc, logic [1:0] wwc, logic is, logic ws);
    int iw, ww, ne;
    longint acc;
    iw  = 2 << ((iwc == 2'd3) ? 2 : int'(iwc));
    ww  = 2 << ((wwc == 2'd3) ? 2 : int'(wwc));
    ne  = 64 / (iw * ww);
    acc = longint'(p);
    for (int e = 0; e < ne; e++) begin
      longint x = 0, y = 0;
      for (int k = 0; k < iw; k++) x = x | (longint'(a[e*iw+k]) << k);
      for (int k = 0; k < ww; k++) y = y | (longint'(b[e*ww+k]) << k);
      if (is && a[e*iw+iw-1]) x = x - (longint'(1) << iw);
      if (ws && b[e*ww+ww-1]) y = y - (longint'(1) << ww);
      acc = acc + x * y;
    end
    return acc[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic drive_ready();
    out_ready = bp_on ? (cyc % 3 != 1) : 1'b1;
  endtask

  // driver: offers a beat and records its expected result on acceptance
  task automatic send(logic [31:0] a, logic [31:0] b, logic [31:0] p, string tag);
    @(negedge clk);
    in_data = a; wt_data = b; psum_in = p; in_valid = 1'b1;
    drive_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      drive_ready();
      #1;
    end
    exp_q.push_back(model(a, b, p, cur_iw, cur_ww, cur_is, cur_ws));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      drive_ready();
    end
  endtask

  task automatic load_cfg(logic [1:0] iw, logic [1:0] ww, logic is, logic ws);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_in_w = iw; cfg_wt_w = ww; cfg_in_sgn = is; cfg_wt_sgn = ws;
    cfg_load = 1'b1;
    drive_ready();
    @(negedge clk);
    cfg_load = 1'b0;
    drive_ready();
    cur_iw = iw; cur_ww = ww; cur_is = is; cur_ws = ws;
  endtask

  // monitor: compares each consumed result, and checks stall behaviour
  always @(negedge clk) begin
    #3;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected result", psum_out, 32'hx);
      end else if (out_ready) begin
        check(tag_q.pop_front(), psum_out, exp_q.pop_front());
      end else begin
        check("R10 stall in_ready", {31'd0, in_ready}, 32'd0);
        check("R10 stall hold", psum_out, exp_q[0]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_in_w = 2'd0; cfg_wt_w = 2'd0;
    cfg_in_sgn = 1'b0; cfg_wt_sgn = 1'b0; in_valid = 1'b0;
    in_data = '0; wt_data = '0; psum_in = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R1 default config: sixteen unsigned 3*3
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R1");
    // R2 2x2 unsigned
    send(32'h1234_5678, 32'h9ABC_DEF0, 32'd5, "R2");
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R2");
    // R6 signed 2x2: (-2)*(-2) sixteen times
    load_cfg(2'd0, 2'd0, 1'b1, 1'b1);
    send(32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'd0, "R6");
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R6");
    load_cfg(2'd0, 2'd0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R6");
    // R3 4x4
    load_cfg(2'd1, 2'd1, 1'b0, 1'b0);
    send(32'h0000_FFFF, 32'h0000_FFFF, 32'd0, "R3");
    send(32'hABCD_FFFF, 32'h1234_FFFF, 32'd0, "R11");
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R3");
    load_cfg(2'd1, 2'd1, 1'b1, 1'b1);
    send(32'h0000_8888, 32'h0000_8888, 32'd0, "R6");
    for (int k = 0; k < 2; k++) send(rnd(), rnd(), rnd(), "R3");
    // R4 mixed widths
    load_cfg(2'd2, 2'd0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R4");
    load_cfg(2'd0, 2'd2, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R4");
    load_cfg(2'd1, 2'd0, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R4");
    load_cfg(2'd0, 2'd1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) send(rnd(), rnd(), rnd(), "R4");
    // R5 8x8
    load_cfg(2'd2, 2'd2, 1'b1, 1'b1);
    send(32'h0000_0080, 32'h0000_0080, 32'd0, "R5");
    send(32'h0000_0080, 32'h0000_007F, 32'd0, "R5");
    send(rnd(), rnd(), rnd(), "R5");
    load_cfg(2'd2, 2'd2, 1'b0, 1'b0);
    send(32'h0000_00FF, 32'h0000_00FF, 32'd0, "R5");
    send(32'h5A5A_5A03, 32'hC3C3_C305, 32'd0, "R11");
    // R7 wrap of partial sum
    load_cfg(2'd0, 2'd0, 1'b0, 1'b0);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF0, "R7");
    load_cfg(2'd0, 2'd0, 1'b1, 1'b0);
    send(32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h0000_0010, "R7");
    // R8 code 3 behaves as 8 bits
    load_cfg(2'd3, 2'd3, 1'b1, 1'b1);
    send(32'h0000_0080, 32'h0000_0080, 32'd0, "R8");
    // R8 beat in the load cycle uses the old (8x8 signed) settings
    idle(2);
    @(negedge clk);
    cfg_in_w = 2'd0; cfg_wt_w = 2'd0; cfg_in_sgn = 1'b0; cfg_wt_sgn = 1'b0;
    cfg_load = 1'b1;
    in_data = 32'hFFFF_FFFF; wt_data = 32'hFFFF_FFFF; psum_in = 32'd0; in_valid = 1'b1;
    drive_ready();
    #1;
    exp_q.push_back(32'd1);
    tag_q.push_back("R8 old settings");
    @(negedge clk);
    cfg_load = 1'b0; in_valid = 1'b0;
    cur_iw = 2'd0; cur_ww = 2'd0; cur_is = 1'b0; cur_ws = 1'b0;
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, "R8 new settings");
    // R9 latency
    idle(3);
    check("R9 idle", {31'd0, out_valid}, 32'd0);
    send(32'h0000_0007, 32'h0000_000B, 32'd1, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    check("R9 latency", {31'd0, out_valid}, 32'd1);
    // R10 back-pressure
    load_cfg(2'd1, 2'd0, 1'b1, 1'b0);
    bp_on = 1'b1;
    for (int k = 0; k < 12; k++) send(rnd(), rnd(), rnd(), "R10");
    idle(12);
    bp_on = 1'b0;
    idle(4);
    check("R10 drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule